// File: doc/BRIEF.md
# Byte-Lane SRAM Controller for an AHB-Lite Subordinate Port

This block connects an AHB-lite subordinate port to four byte-wide synchronous single-port SRAM banks. Together the banks form a 32 KB memory of 32-bit words. All four banks share one word address, and each bank holds one byte lane of the word. The controller keeps the address-phase signals of each write until its data phase. From the transfer size and the low address bits it produces one active-low write enable per bank. The 32-bit read data goes back to the requester as the four bank outputs side by side. Every access finishes in one cycle: HREADYOUT is always 1 and HRESP is always OKAY.

A separate preload port takes priority over the bus. While it is asserted, all four banks are written in the same cycle at the preload address, with the preload data. This lets a test environment place a program in memory before the processor starts. The banks themselves are outside the block. The controller drives their word address, their write data, the four write enables and a chip select that is held active.

The requester must not present a read address phase in the same cycle as a write data phase. In that cycle the bank port carries the write.

Top module: `bytelane_sram_ctrl`

## Requirements
- R1: While in reset, and at every cycle after it with no transfer, `ram_we_n` is 4'b1111. At all times `ram_cs_n` is 0, `hreadyout` is 1 and `hresp` is 0.
- R2: A write address phase with `htrans`=2'b10, `hwrite`=1 and `hsize`=3'b000 pulls low exactly one bit of `ram_we_n` in the next cycle. That bit is bit n, where n = `haddr[1:0]`. Bit n of `ram_we_n` controls byte lane n, which is `ram_wdata[8n+7:8n]`.
- R3: A halfword write (`hsize`=3'b001) gives `ram_we_n`=4'b1100 for offset 2'b00 and 4'b0011 for offset 2'b10. It gives 4'b1111 for offsets 2'b01 and 2'b11.
- R4: A word write (`hsize`=3'b010) at offset 2'b00 gives `ram_we_n`=4'b0000. A word write at any other offset gives 4'b1111, and so does any `hsize` of 3'b011 or above.
- R5: A read (`hwrite`=0) or a transfer of type IDLE (2'b00), BUSY (2'b01) or SEQ (2'b11) leaves `ram_we_n` at 4'b1111 in the next cycle.
- R6: In a write data phase that enables any lane, `ram_addr` equals `haddr[14:2]` as captured in the address phase, whatever `haddr` is now. In the same cycle `ram_wdata` equals the current `hwdata`.
- R7: In a cycle with no enabled write data phase and no preload, `ram_addr` follows the current `haddr[14:2]` combinationally.
- R8: While `load_en` is 1, in the same cycle, `ram_we_n` is 4'b0000, `ram_addr` is `load_addr[14:2]` and `ram_wdata` is `load_data`. The bus inputs have no effect on these outputs during that cycle.
- R9: An address phase presented while `load_en` is 1 is discarded, so no write follows it. A write data phase that falls in a preload cycle is dropped and is not performed later.
- R10: Read data on `hrdata` in a data phase is the word the banks return for the address given in the address phase, with bank lane n on bits [8n+7:8n]. Bytes that a partial write did not enable keep their earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| haddr | input | ADDR_W | Bus byte address (address phase) |
| htrans | input | 2 | Transfer type; only 2'b10 starts a write |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata | input | DATA_W | Write data (data phase) |
| hrdata | output | DATA_W | Read data (data phase) |
| hreadyout | output | 1 | Always 1: no wait states |
| hresp | output | 1 | Always 0: OKAY |
| load_en | input | 1 | Preload request, overrides the bus |
| load_addr | input | ADDR_W | Preload byte address |
| load_data | input | DATA_W | Preload word |
| ram_addr | output | 13 | Shared bank word address |
| ram_wdata | output | DATA_W | Bank write data, lane n on bits [8n+7:8n] |
| ram_we_n | output | 4 | Active-low write enable, bit n for lane n |
| ram_cs_n | output | 1 | Bank chip select, held at 0 |
| ram_rdata | input | DATA_W | Bank read data, lane n on bits [8n+7:8n] |

## Verification
A table of fifteen address-phase patterns drives the write-enable decode. It covers byte writes at all four offsets, and halfword and word writes at aligned and misaligned offsets, which separates lane selection from alignment rejection. It also covers oversize writes, reads, and IDLE, BUSY and SEQ transfers, which separates the write qualifier from the size decode. During each data phase the bench moves `haddr` to an unrelated word, so a captured address can be told apart from a live one. Directed sequences collide preloads with bus address and data phases. Partial writes over preloaded words, then reads, show the merged bytes and show that two back-to-back reads need no stall.

// File: rtl/blsc_pkg.sv
`timescale 1ns/1ps
// Shared codes for the byte-lane SRAM controller.
// Assumes AHB-lite transfer-type and size encodings.
package blsc_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_HALF = 3'b001;
    localparam logic [2:0] SZ_WORD = 3'b010;
endpackage

// File: rtl/blsc_lane_decode.sv
`timescale 1ns/1ps
// Turns a transfer size and byte offset into active-high lane enables.
// A transfer enables lanes only if it fits the word and is naturally aligned;
// anything else enables no lane. Purely combinational.
module blsc_lane_decode #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [2:0]       size,
    input  logic [OFF_W-1:0] offset,
    output logic [LANES-1:0] lane_en
);
    logic             fits;
    logic             aligned;
    logic [OFF_W:0]   span;
    logic [OFF_W:0]   limit;

    // Byte count of the transfer, its alignment and the first lane past it.
    always_comb begin
        fits    = (size <= 3'(OFF_W));
        span    = fits ? ((OFF_W+1)'(1) << size) : '0;
        aligned = ((offset & OFF_W'(span - 1'b1)) == '0);
        limit   = {1'b0, offset} + span;
    end

    // One comparator pair per lane: the lane lies inside [offset, limit).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
        assign lane_en[i] = fits && aligned && ({1'b0, offset} <= IDX) && (IDX < limit);
    end
endmodule

// File: rtl/blsc_phase_reg.sv
`timescale 1ns/1ps
// Holds a write's word address and lane enables from its address phase
// into its data phase. Lanes read as zero when no write is pending.
// Assumes one transfer per cycle (no wait states).
module blsc_phase_reg #(
    parameter int WORD_AW = 13,
    parameter int LANES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [WORD_AW-1:0] word_in,
    input  logic [LANES-1:0]   lanes_in,
    output logic [WORD_AW-1:0] dp_word,
    output logic [LANES-1:0]   dp_lanes
);
    // Capture the address phase of a qualified write, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_word  <= '0;
            dp_lanes <= '0;
        end else begin
            dp_lanes <= capture ? lanes_in : '0;
            if (capture) dp_word <= word_in;
        end
    end
endmodule

// File: rtl/blsc_port_mux.sv
`timescale 1ns/1ps
// Chooses what drives the shared bank port each cycle.
// Priority: preload, then a pending write data phase, then the live
// address phase (which sets up a read). Purely combinational.
module blsc_port_mux #(
    parameter int WORD_AW = 13,
    parameter int DATA_W  = 32,
    parameter int LANES   = 4
) (
    input  logic               load_en,
    input  logic [WORD_AW-1:0] load_word,
    input  logic [DATA_W-1:0]  load_data,
    input  logic [WORD_AW-1:0] dp_word,
    input  logic [LANES-1:0]   dp_lanes,
    input  logic [WORD_AW-1:0] ap_word,
    input  logic [DATA_W-1:0]  hwdata,
    output logic [WORD_AW-1:0] ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    output logic [LANES-1:0]   ram_we_n
);
    // Apply the port priority.
    always_comb begin
        if (load_en) begin
            ram_addr  = load_word;
            ram_wdata = load_data;
            ram_we_n  = '0;
        end else if (|dp_lanes) begin
            ram_addr  = dp_word;
            ram_wdata = hwdata;
            ram_we_n  = ~dp_lanes;
        end else begin
            ram_addr  = ap_word;
            ram_wdata = hwdata;
            ram_we_n  = '1;
        end
    end
endmodule

// File: rtl/bytelane_sram_ctrl.sv
`timescale 1ns/1ps
// Byte-lane SRAM controller for an AHB-lite subordinate port.
// Drives DATA_W/8 byte-wide synchronous single-port banks that share one
// word address. Writes happen in the data phase at the captured address;
// reads address the banks in the address phase so data is ready in the
// data phase. A preload port overrides the bus. Assumes the requester never
// overlaps a read address phase with a write data phase.
module bytelane_sram_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 32768
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    haddr,
    input  logic [1:0]                           htrans,
    input  logic                                 hwrite,
    input  logic [2:0]                           hsize,
    input  logic [DATA_W-1:0]                    hwdata,
    output logic [DATA_W-1:0]                    hrdata,
    output logic                                 hreadyout,
    output logic                                 hresp,
    input  logic                                 load_en,
    input  logic [ADDR_W-1:0]                    load_addr,
    input  logic [DATA_W-1:0]                    load_data,
    output logic [$clog2(MEM_BYTES/(DATA_W/8))-1:0] ram_addr,
    output logic [DATA_W-1:0]                    ram_wdata,
    output logic [DATA_W/8-1:0]                  ram_we_n,
    output logic                                 ram_cs_n,
    input  logic [DATA_W-1:0]                    ram_rdata
);
    import blsc_pkg::*;

    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int WORD_AW = $clog2(MEM_BYTES / LANES);
    localparam int ADDR_HI = OFF_W + WORD_AW;

    logic [LANES-1:0]   ap_lanes;
    logic [LANES-1:0]   dp_lanes;
    logic [WORD_AW-1:0] dp_word;
    logic               ap_write;
    logic               unused_addr_bits;

    // A write starts only on a NONSEQ write that is not shadowed by a preload.
    assign ap_write = (htrans == TR_NONSEQ) && hwrite && !load_en;

    blsc_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
        .size    (hsize),
        .offset  (haddr[OFF_W-1:0]),
        .lane_en (ap_lanes)
    );

    blsc_phase_reg #(.WORD_AW(WORD_AW), .LANES(LANES)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ap_write),
        .word_in  (haddr[ADDR_HI-1:OFF_W]),
        .lanes_in (ap_lanes),
        .dp_word  (dp_word),
        .dp_lanes (dp_lanes)
    );

    blsc_port_mux #(.WORD_AW(WORD_AW), .DATA_W(DATA_W), .LANES(LANES)) u_mux (
        .load_en   (load_en),
        .load_word (load_addr[ADDR_HI-1:OFF_W]),
        .load_data (load_data),
        .dp_word   (dp_word),
        .dp_lanes  (dp_lanes),
        .ap_word   (haddr[ADDR_HI-1:OFF_W]),
        .hwdata    (hwdata),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we_n  (ram_we_n)
    );

    // Read data is the bank lanes side by side; no stalls, no errors.
    assign hrdata    = ram_rdata;
    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;
    assign ram_cs_n  = 1'b0;

    // Address bits above the memory and the preload byte offset are not decoded.
    assign unused_addr_bits = ^{haddr[ADDR_W-1:ADDR_HI], load_addr[ADDR_W-1:ADDR_HI],
                                load_addr[OFF_W-1:0]};
endmodule

// File: rtl/blsc_checker.sv
`timescale 1ns/1ps
// Protocol checker for bytelane_sram_ctrl, attached by bind.
// Assumes a synchronous active-low reset.
module blsc_checker #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 32768
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [ADDR_W-1:0]                    haddr,
    input logic [1:0]                           htrans,
    input logic                                 hwrite,
    input logic [2:0]                           hsize,
    input logic [DATA_W-1:0]                    hwdata,
    input logic                                 hreadyout,
    input logic                                 hresp,
    input logic                                 load_en,
    input logic [ADDR_W-1:0]                    load_addr,
    input logic [DATA_W-1:0]                    load_data,
    input logic [$clog2(MEM_BYTES/(DATA_W/8))-1:0] ram_addr,
    input logic [DATA_W-1:0]                    ram_wdata,
    input logic [DATA_W/8-1:0]                  ram_we_n,
    input logic                                 ram_cs_n
);
    import blsc_pkg::*;

    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int WORD_AW = $clog2(MEM_BYTES / LANES);
    localparam int ADDR_HI = OFF_W + WORD_AW;

    logic             seen;
    logic             was_write;
    logic [WORD_AW-1:0] cur_word;
    logic             unused_chk_bits;

    // Marks that one clock edge has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assign was_write = (htrans == TR_NONSEQ) && hwrite && !load_en;
    assign cur_word  = haddr[ADDR_HI-1:OFF_W];
    assign unused_chk_bits = ^{haddr[ADDR_W-1:ADDR_HI], load_addr[ADDR_W-1:ADDR_HI],
                               load_addr[OFF_W-1:0]};

    // R1: fixed handshake and chip select.
    p_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hreadyout && !hresp && !ram_cs_n);

    // R8: preload drives the whole port.
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (ram_we_n == '0) && (ram_addr == load_addr[ADDR_HI-1:OFF_W])
                    && (ram_wdata == load_data));

    // R5 and R9: no write unless a qualified write address phase preceded.
    p_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !load_en && !$past(was_write)) |-> (&ram_we_n));

    // R2: a byte write enables exactly the addressed lane.
    p_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !load_en && $past(was_write && hsize == SZ_BYTE))
        |-> ($countones(~ram_we_n) == 1) && !ram_we_n[$past(haddr[OFF_W-1:0])]);

    // R3: a halfword write enables two lanes or none.
    p_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !load_en && $past(was_write && hsize == SZ_HALF))
        |-> ($countones(~ram_we_n) == 2) || (&ram_we_n));

    // R4: a word write enables all lanes or none.
    p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !load_en && $past(was_write && hsize == SZ_WORD))
        |-> (ram_we_n == '0) || (&ram_we_n));

    // R6: a data-phase write uses the captured address and live write data.
    p_dpaddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !load_en && !(&ram_we_n))
        |-> (ram_addr == $past(cur_word)) && (ram_wdata == hwdata));

    // R7: with no write on the port, the address follows the bus.
    p_apaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (&ram_we_n)) |-> (ram_addr == cur_word));
endmodule

bind bytelane_sram_ctrl blsc_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MEM_BYTES (MEM_BYTES)
) u_blsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hwdata    (hwdata),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we_n  (ram_we_n),
    .ram_cs_n  (ram_cs_n)
);

// File: tb/bytelane_sram_ctrl_test.sv
`timescale 1ns/1ps
// Bench for bytelane_sram_ctrl: a vector table for the enable decode, then
// directed preload, collision and read-back sequences. Inputs change at the
// falling edge; outputs are sampled 1 ns later.
module bytelane_sram_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] haddr, hwdata, hrdata, load_addr, load_data, ram_wdata, ram_rdata;
    logic [1:0]  htrans;
    logic        hwrite, hreadyout, hresp, load_en, ram_cs_n;
    logic [2:0]  hsize;
    logic [12:0] ram_addr;
    logic [3:0]  ram_we_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bytelane_sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hreadyout(hreadyout),
        .hresp(hresp), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we_n(ram_we_n),
        .ram_cs_n(ram_cs_n), .ram_rdata(ram_rdata)
    );

    // Behavioural banks, read-before-write, covering the low 256 words.
    logic [31:0] mem [256];
    initial for (int k = 0; k < 256; k++) mem[k] = '0;
    always @(posedge clk) begin
        for (int ln = 0; ln < 4; ln++)
            if (!ram_we_n[ln]) mem[ram_addr[7:0]][8*ln +: 8] <= ram_wdata[8*ln +: 8];
        ram_rdata <= mem[ram_addr[7:0]];
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_idle();
        htrans = 2'b00; hwrite = 1'b0; hsize = 3'b000; load_en = 1'b0;
    endtask

    // Vector: [11:10] htrans, [9] hwrite, [8:6] hsize, [5:4] offset, [3:0] ram_we_n.
    localparam logic [11:0] VEC [15] = '{
        {2'b10, 1'b1, 3'd0, 2'd0, 4'b1110},
        {2'b10, 1'b1, 3'd0, 2'd1, 4'b1101},
        {2'b10, 1'b1, 3'd0, 2'd2, 4'b1011},
        {2'b10, 1'b1, 3'd0, 2'd3, 4'b0111},
        {2'b10, 1'b1, 3'd1, 2'd0, 4'b1100},
        {2'b10, 1'b1, 3'd1, 2'd2, 4'b0011},
        {2'b10, 1'b1, 3'd1, 2'd1, 4'b1111},
        {2'b10, 1'b1, 3'd1, 2'd3, 4'b1111},
        {2'b10, 1'b1, 3'd2, 2'd0, 4'b0000},
        {2'b10, 1'b1, 3'd2, 2'd2, 4'b1111},
        {2'b10, 1'b1, 3'd3, 2'd0, 4'b1111},
        {2'b10, 1'b0, 3'd2, 2'd0, 4'b1111},
        {2'b00, 1'b1, 3'd2, 2'd0, 4'b1111},
        {2'b01, 1'b1, 3'd2, 2'd0, 4'b1111},
        {2'b11, 1'b1, 3'd2, 2'd0, 4'b1111}
    };

    function automatic string tag_of(input logic [11:0] v);
        if (v[11:10] != 2'b10 || !v[9]) return "R5";
        if (v[8:6] == 3'd0) return "R2";
        if (v[8:6] == 3'd1) return "R3";
        return "R4";
    endfunction

    // One write: address phase, then data phase with haddr moved elsewhere.
    task automatic write_xfer(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        haddr = a; htrans = 2'b10; hwrite = 1'b1; hsize = sz;
        @(negedge clk);
        bus_idle(); haddr = 32'h0000_03F0; hwdata = d;
    endtask

    task automatic read_check(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        haddr = a; htrans = 2'b10; hwrite = 1'b0; hsize = 3'd2;
        @(negedge clk);
        bus_idle();
        #1 check(tag, hrdata, exp);
    endtask

    initial begin
        rst_n = 1'b0; bus_idle(); haddr = '0; hwdata = '0; load_addr = '0; load_data = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset we_n", {28'd0, ram_we_n}, 32'hF);
        check("R1 reset cs_n", {31'd0, ram_cs_n}, 32'h0);
        check("R1 reset ready", {31'd0, hreadyout}, 32'h1);
        check("R1 reset resp", {31'd0, hresp}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 idle we_n", {28'd0, ram_we_n}, 32'hF);
        check("R1 idle ready", {31'd0, hreadyout}, 32'h1);

        // Decode table: address phase at word 0x40, data phase with haddr at word 0x80.
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            haddr = 32'h0000_0100 + {30'd0, VEC[i][5:4]};
            htrans = VEC[i][11:10]; hwrite = VEC[i][9]; hsize = VEC[i][8:6];
            @(negedge clk);
            bus_idle(); haddr = 32'h0000_0200; hwdata = 32'hA500_0000 | i;
            #1 check(tag_of(VEC[i]), {28'd0, ram_we_n}, {28'd0, VEC[i][3:0]});
            if (VEC[i][3:0] != 4'hF) begin
                check("R6 captured addr", {19'd0, ram_addr}, 32'h40);
                check("R6 data phase wdata", ram_wdata, hwdata);
            end else begin
                check("R7 live addr", {19'd0, ram_addr}, 32'h80);
            end
        end

        // R8: preload wins over a simultaneous bus write address phase.
        @(negedge clk);
        load_en = 1'b1; load_addr = 32'h0000_0008; load_data = 32'h1122_3344;
        haddr = 32'h0000_0300; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2;
        #1;
        check("R8 load we_n", {28'd0, ram_we_n}, 32'h0);
        check("R8 load addr", {19'd0, ram_addr}, 32'h2);
        check("R8 load wdata", ram_wdata, 32'h1122_3344);
        @(negedge clk); bus_idle(); haddr = 32'h0000_0040;
        #1 check("R9 discarded addr phase", {28'd0, ram_we_n}, 32'hF);
        @(negedge clk);
        load_en = 1'b1; load_addr = 32'h0000_0010; load_data = 32'hCAFE_F00D;
        @(negedge clk); load_en = 1'b0;

        // R9: write data phase colliding with preload is dropped.
        write_xfer(32'h0000_0018, 3'd2, 32'hDEAD_BEEF);
        load_en = 1'b1; load_addr = 32'h0000_001C; load_data = 32'h7777_7777;
        #1;
        check("R9 collide we_n", {28'd0, ram_we_n}, 32'h0);
        check("R9 collide addr", {19'd0, ram_addr}, 32'h7);
        check("R9 collide wdata", ram_wdata, 32'h7777_7777);
        @(negedge clk); load_en = 1'b0;
        #1 check("R9 not deferred", {28'd0, ram_we_n}, 32'hF);

        // R10: partial writes merged over preloaded words, then read back.
        write_xfer(32'h0000_0009, 3'd0, 32'h0000_AA00);
        read_check(32'h0000_0008, 32'h1122_AA44, "R10 byte merge");
        write_xfer(32'h0000_0012, 3'd1, 32'hBEEF_0000);
        read_check(32'h0000_0010, 32'hBEEF_F00D, "R10 halfword merge");

        // R7/R10: back-to-back reads with no stall; word 6 never written.
        @(negedge clk);
        haddr = 32'h0000_0018; htrans = 2'b10; hwrite = 1'b0; hsize = 3'd2;
        #1 check("R7 read addr", {19'd0, ram_addr}, 32'h6);
        @(negedge clk);
        haddr = 32'h0000_001C;
        #1 check("R10 first read", hrdata, 32'h0);
        @(negedge clk); bus_idle();
        #1 check("R10 second read", hrdata, 32'h7777_7777);
        check("R1 ready after traffic", {31'd0, hreadyout}, 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule